// File: doc/BRIEF.md
# Paged Expanded Memory Mapper

This block sits between an 8-bit ISA-style bus with a 20-bit memory space and a bank of external byte-wide memory devices. A 64 KB window in the CPU memory space, placed at a programmable 64 KB boundary, is divided into four 16 KB banks. CPU address bits 15:14 choose the bank. Each bank has an 8-bit page number, and that page number picks which 16 KB page of the external memory the bank shows. An 8-bit page number covers 256 pages, so up to 4 MB can be reached through the window. Software loads the page numbers through four consecutive I/O ports at a programmable I/O base, which is 8-byte aligned.

Each page number has two fields. The low five bits become external address lines 18:14 and select a 16 KB page inside one device. The upper bits are decoded to one active-low chip select. With the default setting, three bits give eight selects. A parameter narrows this to two bits and four selects. CPU address bits 13:0 pass straight through to the devices. A reset-cleared page-enable flag holds every bank on page 0 until software enables paging, so that a boot extension stored at page 0 is visible after reset. There are two ways to set the flag. One variant has a dedicated enable port at I/O base+4. The other variant sets the flag on any page-register write. The device write enable goes either to a flash-style write pin or to an SRAM-style write pin, chosen by a mode input.

I/O writes are handled by a three-state sequencer: `IO_IDLE`, `IO_HELD` and `IO_FOREIGN`.
- `IO_IDLE` goes to `IO_HELD` when IOW# is low and the address decodes to this block.
- `IO_IDLE` goes to `IO_FOREIGN` when IOW# is low and the address does not decode to this block.
- `IO_HELD` stays in place while IOW# is low and re-captures the data each cycle.
- `IO_HELD` goes back to `IO_IDLE` when IOW# rises. On that cycle it commits the captured port and data.
- `IO_FOREIGN` goes back to `IO_IDLE` when IOW# rises, and it commits nothing.

Top module: `ems_page_mapper`

## Requirements
- R1: After reset every page register holds 0 and the page-enable flag is clear.
- R2: An I/O write to base+n (n = 0..3, matched on address bits 9:3 against `io_base` and bits 2:0 = n) loads bank n with the data present on the last clock where IOW# was low. The new value is visible from the first clock after IOW# is sampled high. Writes to other ports, and strobes that began at a non-matching address, change nothing.
- R3: Within the window, `mem_addr[18:14]` equals bits 4:0 of the selected bank's effective page, where the bank is CPU bits 15:14. `mem_addr[13:0]` equals CPU bits 13:0.
- R4: With three chip-select bits, page bits 7:5 = k drives `chip_sel_n[k]` low, and the other selects stay high. In the four-select variant, page bits 6:5 choose the select and bit 7 is ignored.
- R5: All chip selects, `mem_oe_n`, `flash_we_n` and `sram_we_n` stay high unless CPU bits 19:16 equal `win_base` and MEMR# or MEMW# is low. `mem_oe_n` follows MEMR# and the write strobes follow MEMW#.
- R6: While the page-enable flag is clear, every bank uses page 0 (device address bits 18:14 = 0 and chip select 0), whatever the registers hold.
- R7: In the enable-port variant, a write to base+4 loads the flag from data bit 0, and page-register writes leave the flag alone. In the write-enables variant, any write to base+0..3 sets the flag, and base+4 is ignored.
- R8: With `flash_mode` high, a windowed memory write drives `flash_we_n` low and keeps `sram_we_n` high. With `flash_mode` low, the roles swap.
- R9: Changing `win_base` or `io_base` moves the memory window or the register ports. The old addresses then no longer respond.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus-synchronous clock |
| rst_n | input | 1 | Active-low system reset, asynchronous |
| bus_addr | input | 20 | CPU address, shared by memory and I/O cycles |
| bus_data | input | 8 | CPU write data |
| io_wr_n | input | 1 | I/O write strobe, active low |
| mem_rd_n | input | 1 | Memory read strobe, active low |
| mem_wr_n | input | 1 | Memory write strobe, active low |
| win_base | input | 4 | Window base, compared with CPU bits 19:16 |
| io_base | input | 7 | I/O base, compared with CPU bits 9:3 |
| flash_mode | input | 1 | 1 routes writes to the flash pin, 0 to the SRAM pin |
| mem_addr | output | 19 | Device address: page bits over the passed-through offset |
| chip_sel_n | output | 8 | One-of-N device selects, active low |
| mem_oe_n | output | 1 | Device output enable, active low |
| flash_we_n | output | 1 | Write enable for flash-style devices, active low |
| sram_we_n | output | 1 | Write enable for SRAM-style devices, active low |

## Verification
A corrupted page register or enable flag shows up on the next windowed access to the affected bank. It appears as a wrong value on `mem_addr[18:14]` or as the wrong chip select falling, in the same cycle as the access. A sequencer stuck in `IO_FOREIGN` or `IO_HELD` shows up as a lost or early commit. The first memory access after the IOW# rise then translates through the stale or premature page. The bench compares every cycle against a behavioural model, so each such fault is reported at the first access that can see it. Two instances run side by side, one per enable variant and chip-select width. A flag or select-field fault therefore also appears as a divergence between the two variants.

// File: rtl/ems_pkg.sv
package ems_pkg;

    typedef enum logic [1:0] {
        IO_IDLE    = 2'd0,
        IO_HELD    = 2'd1,
        IO_FOREIGN = 2'd2
    } io_state_t;

endpackage

// File: rtl/ems_io_decode.sv
module ems_io_decode #(
    parameter int IO_W            = 10,
    parameter int IO_ALIGN        = 3,
    parameter int NUM_BANKS       = 4,
    parameter bit EN_ON_ANY_WRITE = 1'b0
) (
    input  logic [IO_W-1:0]          io_addr,
    input  logic [IO_W-IO_ALIGN-1:0] io_base,
    output logic                     io_hit,
    output logic [IO_ALIGN-1:0]      io_slot
);

    localparam logic [IO_ALIGN-1:0] EN_SLOT = IO_ALIGN'(NUM_BANKS);

    logic base_match;
    logic slot_ok;

    assign base_match = (io_addr[IO_W-1:IO_ALIGN] == io_base);
    assign io_slot    = io_addr[IO_ALIGN-1:0];

    generate
        if (EN_ON_ANY_WRITE) begin : g_no_en_port
            assign slot_ok = (io_slot < EN_SLOT);
        end else begin : g_en_port
            assign slot_ok = (io_slot <= EN_SLOT);
        end
    endgenerate

    assign io_hit = base_match && slot_ok;

endmodule

// File: rtl/ems_page_regfile.sv
module ems_page_regfile #(
    parameter int NUM_BANKS       = 4,
    parameter int PAGE_W          = 8,
    parameter int SLOT_W          = 3,
    parameter bit EN_ON_ANY_WRITE = 1'b0,
    localparam int BANK_W         = $clog2(NUM_BANKS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SLOT_W-1:0] wr_slot,
    input  logic [PAGE_W-1:0] wr_data,
    input  logic [BANK_W-1:0] rd_bank,
    output logic [PAGE_W-1:0] rd_page,
    output logic              page_en
);

    localparam logic [SLOT_W-1:0] EN_SLOT = SLOT_W'(NUM_BANKS);

    logic [PAGE_W-1:0] pages [NUM_BANKS];
    logic              bank_wr;

    assign bank_wr = wr_en && (wr_slot < EN_SLOT);

    // write port: committed bus data
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_BANKS; i++) begin
                pages[i] <= '0;
            end
        end else if (bank_wr) begin
            pages[wr_slot[BANK_W-1:0]] <= wr_data;
        end
    end

    // enable flag, variant chosen by parameter
    generate
        if (EN_ON_ANY_WRITE) begin : g_en_any
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    page_en <= 1'b0;
                end else if (bank_wr) begin
                    page_en <= 1'b1;
                end
            end
        end else begin : g_en_port
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    page_en <= 1'b0;
                end else if (wr_en && (wr_slot == EN_SLOT)) begin
                    page_en <= wr_data[0];
                end
            end
        end
    endgenerate

    // read port: independent of the write port
    assign rd_page = page_en ? pages[rd_bank] : '0;

endmodule

// File: rtl/ems_addr_xlate.sv
module ems_addr_xlate #(
    parameter int ADDR_W      = 20,
    parameter int WIN_W       = 16,
    parameter int BANK_W      = 2,
    parameter int PAGE_W      = 8,
    parameter int INDEV_W     = 5,
    parameter int CS_SEL_BITS = 3,
    localparam int OFFS_W     = WIN_W - BANK_W,
    localparam int MEM_AW     = OFFS_W + INDEV_W,
    localparam int WBASE_W    = ADDR_W - WIN_W,
    localparam int NUM_CS     = 1 << CS_SEL_BITS
) (
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [WBASE_W-1:0] win_base,
    input  logic [PAGE_W-1:0]  page,
    input  logic               mem_rd_n,
    input  logic               mem_wr_n,
    input  logic               flash_mode,
    output logic [BANK_W-1:0]  bank,
    output logic [MEM_AW-1:0]  mem_addr,
    output logic [NUM_CS-1:0]  chip_sel_n,
    output logic               mem_oe_n,
    output logic               flash_we_n,
    output logic               sram_we_n
);

    logic                   win_hit;
    logic                   access;
    logic                   wr_act;
    logic [CS_SEL_BITS-1:0] cs_idx;

    assign win_hit = (bus_addr[ADDR_W-1:WIN_W] == win_base);
    assign access  = win_hit && (!mem_rd_n || !mem_wr_n);
    assign wr_act  = win_hit && !mem_wr_n;
    assign bank    = bus_addr[WIN_W-1:OFFS_W];

    assign mem_addr = {page[INDEV_W-1:0], bus_addr[OFFS_W-1:0]};
    assign cs_idx   = page[INDEV_W +: CS_SEL_BITS];

    generate
        for (genvar k = 0; k < NUM_CS; k++) begin : g_cs
            assign chip_sel_n[k] = !(access && (cs_idx == CS_SEL_BITS'(k)));
        end
    endgenerate

    assign mem_oe_n   = !(win_hit && !mem_rd_n);
    assign flash_we_n = !(wr_act && flash_mode);
    assign sram_we_n  = !(wr_act && !flash_mode);

endmodule

// File: rtl/ems_page_mapper.sv
module ems_page_mapper #(
    parameter int ADDR_W          = 20,
    parameter int WIN_W           = 16,
    parameter int NUM_BANKS       = 4,
    parameter int PAGE_W          = 8,
    parameter int INDEV_W         = 5,
    parameter int CS_SEL_BITS     = 3,
    parameter int IO_W            = 10,
    parameter int IO_ALIGN        = 3,
    parameter bit EN_ON_ANY_WRITE = 1'b0,
    localparam int BANK_W         = $clog2(NUM_BANKS),
    localparam int OFFS_W         = WIN_W - BANK_W,
    localparam int MEM_AW         = OFFS_W + INDEV_W,
    localparam int WBASE_W        = ADDR_W - WIN_W,
    localparam int IOB_W          = IO_W - IO_ALIGN,
    localparam int NUM_CS         = 1 << CS_SEL_BITS
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [PAGE_W-1:0]  bus_data,
    input  logic               io_wr_n,
    input  logic               mem_rd_n,
    input  logic               mem_wr_n,
    input  logic [WBASE_W-1:0] win_base,
    input  logic [IOB_W-1:0]   io_base,
    input  logic               flash_mode,
    output logic [MEM_AW-1:0]  mem_addr,
    output logic [NUM_CS-1:0]  chip_sel_n,
    output logic               mem_oe_n,
    output logic               flash_we_n,
    output logic               sram_we_n
);

    import ems_pkg::*;

    io_state_t           state_q;
    io_state_t           state_d;
    logic                commit;
    logic                io_hit;
    logic [IO_ALIGN-1:0] io_slot;
    logic [IO_ALIGN-1:0] cap_slot_q;
    logic [PAGE_W-1:0]   cap_data_q;
    logic [BANK_W-1:0]   bank;
    logic [PAGE_W-1:0]   page;
    logic                page_en;

    ems_io_decode #(
        .IO_W           (IO_W),
        .IO_ALIGN       (IO_ALIGN),
        .NUM_BANKS      (NUM_BANKS),
        .EN_ON_ANY_WRITE(EN_ON_ANY_WRITE)
    ) u_dec (
        .io_addr(bus_addr[IO_W-1:0]),
        .io_base(io_base),
        .io_hit (io_hit),
        .io_slot(io_slot)
    );

    // state register and capture latches
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= IO_IDLE;
            cap_slot_q <= '0;
            cap_data_q <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == IO_IDLE && state_d == IO_HELD) begin
                cap_slot_q <= io_slot;
            end
            if (state_d == IO_HELD) begin
                cap_data_q <= bus_data;
            end
        end
    end

    // next state and commit strobe
    always_comb begin
        state_d = state_q;
        commit  = 1'b0;
        unique case (state_q)
            IO_IDLE: begin
                if (!io_wr_n) begin
                    state_d = io_hit ? IO_HELD : IO_FOREIGN;
                end
            end
            IO_HELD: begin
                if (io_wr_n) begin
                    commit  = 1'b1;
                    state_d = IO_IDLE;
                end
            end
            IO_FOREIGN: begin
                if (io_wr_n) begin
                    state_d = IO_IDLE;
                end
            end
            default: begin
                state_d = IO_IDLE;
            end
        endcase
    end

    ems_page_regfile #(
        .NUM_BANKS      (NUM_BANKS),
        .PAGE_W         (PAGE_W),
        .SLOT_W         (IO_ALIGN),
        .EN_ON_ANY_WRITE(EN_ON_ANY_WRITE)
    ) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (commit),
        .wr_slot(cap_slot_q),
        .wr_data(cap_data_q),
        .rd_bank(bank),
        .rd_page(page),
        .page_en(page_en)
    );

    ems_addr_xlate #(
        .ADDR_W     (ADDR_W),
        .WIN_W      (WIN_W),
        .BANK_W     (BANK_W),
        .PAGE_W     (PAGE_W),
        .INDEV_W    (INDEV_W),
        .CS_SEL_BITS(CS_SEL_BITS)
    ) u_xlate (
        .bus_addr  (bus_addr),
        .win_base  (win_base),
        .page      (page),
        .mem_rd_n  (mem_rd_n),
        .mem_wr_n  (mem_wr_n),
        .flash_mode(flash_mode),
        .bank      (bank),
        .mem_addr  (mem_addr),
        .chip_sel_n(chip_sel_n),
        .mem_oe_n  (mem_oe_n),
        .flash_we_n(flash_we_n),
        .sram_we_n (sram_we_n)
    );

endmodule

// File: rtl/ems_page_mapper_chk.sv
module ems_page_mapper_chk #(
    parameter int WBASE_W = 4,
    parameter int PG_W    = 5,
    parameter int NUM_CS  = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic [WBASE_W-1:0]  win_addr,
    input logic [WBASE_W-1:0]  win_base,
    input logic                mem_rd_n,
    input logic                mem_wr_n,
    input logic [PG_W-1:0]     page_bits,
    input logic [NUM_CS-1:0]   chip_sel_n,
    input logic                mem_oe_n,
    input logic                flash_we_n,
    input logic                sram_we_n,
    input logic                page_en,
    input ems_pkg::io_state_t  state_q
);

    logic access;
    assign access = (win_addr == win_base) && (!mem_rd_n || !mem_wr_n);

    // R5: nothing selected or strobed outside a windowed memory cycle
    a_r5_quiet_outside: assert property (@(posedge clk) disable iff (!rst_n)
        !access |-> (&chip_sel_n && mem_oe_n && flash_we_n && sram_we_n));

    // R4: at most one device selected
    a_r4_single_select: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~chip_sel_n));

    // R4: a windowed cycle selects exactly one device
    a_r4_select_on_access: assert property (@(posedge clk) disable iff (!rst_n)
        access |-> ($countones(~chip_sel_n) == 1));

    // R6: flag clear pins every bank to page 0
    a_r6_page_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !page_en |-> (page_bits == '0 && (!access || !chip_sel_n[0])));

    // R8: never both write pins at once
    a_r8_one_write_pin: assert property (@(posedge clk) disable iff (!rst_n)
        !(!flash_we_n && !sram_we_n));

    // R7: the flag moves only on a commit out of the held state
    a_r7_flag_needs_commit: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ems_pkg::IO_HELD) |=> $stable(page_en));

endmodule

bind ems_page_mapper ems_page_mapper_chk #(
    .WBASE_W(WBASE_W),
    .PG_W   (INDEV_W),
    .NUM_CS (NUM_CS)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .win_addr  (bus_addr[ADDR_W-1:WIN_W]),
    .win_base  (win_base),
    .mem_rd_n  (mem_rd_n),
    .mem_wr_n  (mem_wr_n),
    .page_bits (mem_addr[MEM_AW-1:OFFS_W]),
    .chip_sel_n(chip_sel_n),
    .mem_oe_n  (mem_oe_n),
    .flash_we_n(flash_we_n),
    .sram_we_n (sram_we_n),
    .page_en   (page_en),
    .state_q   (state_q)
);

// File: tb/test_ems_page_mapper.sv
module test_ems_page_mapper;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [19:0] bus_addr = '0;
    logic [7:0]  bus_data = '0;
    logic        io_wr_n = 1'b1;
    logic        mem_rd_n = 1'b1;
    logic        mem_wr_n = 1'b1;
    logic [3:0]  win_base = 4'hE;
    logic [6:0]  io_base = 7'h4C;
    logic        flash_mode = 1'b1;

    logic [18:0] ma0, ma1;
    logic [7:0]  cs0_n;
    logic [3:0]  cs1_n;
    logic        oe0_n, oe1_n, fwe0_n, fwe1_n, swe0_n, swe1_n;

    int    vectors = 0;
    int    miscompares = 0;
    bit    run_cmp = 1'b0;
    bit    done = 1'b0;
    string cur_req = "R1";

    always #5 clk = ~clk;

    // variant A: enable port at base+4, eight selects
    ems_page_mapper i_ems_page_mapper (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_data(bus_data),
        .io_wr_n(io_wr_n), .mem_rd_n(mem_rd_n), .mem_wr_n(mem_wr_n),
        .win_base(win_base), .io_base(io_base), .flash_mode(flash_mode),
        .mem_addr(ma0), .chip_sel_n(cs0_n), .mem_oe_n(oe0_n),
        .flash_we_n(fwe0_n), .sram_we_n(swe0_n));

    // variant B: any register write enables, four selects
    ems_page_mapper #(.EN_ON_ANY_WRITE(1'b1), .CS_SEL_BITS(2)) i_ems_page_mapper_b (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_data(bus_data),
        .io_wr_n(io_wr_n), .mem_rd_n(mem_rd_n), .mem_wr_n(mem_wr_n),
        .win_base(win_base), .io_base(io_base), .flash_mode(flash_mode),
        .mem_addr(ma1), .chip_sel_n(cs1_n), .mem_oe_n(oe1_n),
        .flash_we_n(fwe1_n), .sram_we_n(swe1_n));

    // behavioural reference
    int m_page [4];
    bit m_en_a, m_en_b;
    int m_phase;      // 0 idle, 1 captured, 2 ignored strobe
    int m_slot, m_data;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            foreach (m_page[i]) m_page[i] = 0;
            m_en_a = 0; m_en_b = 0; m_phase = 0; m_slot = 0; m_data = 0;
        end else if (m_phase == 1) begin
            if (io_wr_n) begin
                if (m_slot < 4) begin
                    m_page[m_slot] = m_data;
                    m_en_b = 1;
                end else begin
                    m_en_a = m_data[0];
                end
                m_phase = 0;
            end else begin
                m_data = bus_data;
            end
        end else if (m_phase == 2) begin
            if (io_wr_n) m_phase = 0;
        end else if (!io_wr_n) begin
            if (bus_addr[9:3] == io_base && bus_addr[2:0] <= 3'd4) begin
                m_phase = 1; m_slot = bus_addr[2:0]; m_data = bus_data;
            end else begin
                m_phase = 2;
            end
        end
    end

    task automatic cmp(string what, int act, int exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", cur_req, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (run_cmp && !done) begin
            bit hit, acc;
            int bank, pa, pb;
            hit  = (bus_addr[19:16] == win_base);
            acc  = hit && (!mem_rd_n || !mem_wr_n);
            bank = bus_addr[15:14];
            pa   = m_en_a ? m_page[bank] : 0;
            pb   = m_en_b ? m_page[bank] : 0;
            cmp("A mem_addr", ma0, ((pa & 31) << 14) | bus_addr[13:0]);
            cmp("B mem_addr", ma1, ((pb & 31) << 14) | bus_addr[13:0]);
            cmp("A chip_sel_n", cs0_n, acc ? (8'hFF ^ (1 << ((pa >> 5) & 7))) : 8'hFF);
            cmp("B chip_sel_n", cs1_n, acc ? (4'hF ^ (1 << ((pb >> 5) & 3))) : 4'hF);
            cmp("A mem_oe_n", oe0_n, !(hit && !mem_rd_n));
            cmp("B mem_oe_n", oe1_n, !(hit && !mem_rd_n));
            cmp("A flash_we_n", fwe0_n, !(hit && !mem_wr_n && flash_mode));
            cmp("B flash_we_n", fwe1_n, !(hit && !mem_wr_n && flash_mode));
            cmp("A sram_we_n", swe0_n, !(hit && !mem_wr_n && !flash_mode));
            cmp("B sram_we_n", swe1_n, !(hit && !mem_wr_n && !flash_mode));
        end
    end

    task automatic step();
        @(posedge clk); #2;
    endtask

    task automatic io_wr(input logic [9:0] a, input logic [7:0] d);
        bus_addr = {10'h000, a}; bus_data = d; io_wr_n = 1'b0;
        step();
        bus_data = d; step();
        io_wr_n = 1'b1; step();
    endtask

    task automatic mem_cyc(input logic [19:0] a, input bit wr);
        bus_addr = a;
        if (wr) mem_wr_n = 1'b0; else mem_rd_n = 1'b0;
        step();
        mem_rd_n = 1'b1; mem_wr_n = 1'b1;
        step();
    endtask

    task automatic sweep_banks(input logic [3:0] seg);
        for (int b = 0; b < 4; b++) begin
            mem_cyc({seg, 2'(b), 14'h1A5 + 14'(b * 977)}, 1'b0);
            mem_cyc({seg, 2'(b), 14'h3FFF - 14'(b)}, 1'b1);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2 run_cmp = 1'b1;
        // R1: reset state, page 0 and chip select 0
        cur_req = "R1";
        step(); step();
        rst_n = 1'b1;
        step();
        sweep_banks(4'hE);

        // R6: registers loaded, enable port untouched (A stays on page 0)
        cur_req = "R6";
        io_wr(10'h260, 8'hE5);
        io_wr(10'h261, 8'h1F);
        io_wr(10'h262, 8'hA3);
        io_wr(10'h263, 8'h7C);
        sweep_banks(4'hE);

        // R7: enable port loads flag from bit 0
        cur_req = "R7";
        io_wr(10'h264, 8'h01);
        sweep_banks(4'hE);
        io_wr(10'h264, 8'hFE);
        sweep_banks(4'hE);
        io_wr(10'h264, 8'h03);

        // R3 / R4: translation and chip-select decode over assorted pages
        cur_req = "R3";
        sweep_banks(4'hE);
        cur_req = "R4";
        io_wr(10'h260, 8'hFF);
        io_wr(10'h261, 8'h80);
        io_wr(10'h262, 8'h40);
        io_wr(10'h263, 8'h00);
        sweep_banks(4'hE);

        // R2: ignored ports, other bases, strobe that starts elsewhere
        cur_req = "R2";
        io_wr(10'h265, 8'h11);
        io_wr(10'h267, 8'h22);
        io_wr(10'h268, 8'h33);
        io_wr(10'h360, 8'h44);
        bus_addr = 20'h00250; bus_data = 8'h55; io_wr_n = 1'b0; step();
        bus_addr = 20'h00261; step();
        io_wr_n = 1'b1; step();
        sweep_banks(4'hE);
        // data changes while IOW# held: last low-cycle value wins
        bus_addr = 20'h00262; bus_data = 8'h12; io_wr_n = 1'b0; step();
        bus_data = 8'h9B; step();
        io_wr_n = 1'b1; bus_data = 8'h00; step();
        sweep_banks(4'hE);

        // R5: outside the window and without strobes
        cur_req = "R5";
        sweep_banks(4'hD);
        sweep_banks(4'hF);
        bus_addr = 20'hE8123; step(); step();

        // R8: write pin routing
        cur_req = "R8";
        flash_mode = 1'b0;
        sweep_banks(4'hE);
        flash_mode = 1'b1;
        mem_cyc(20'hEC000, 1'b1);

        // R9: relocated window and I/O ports
        cur_req = "R9";
        win_base = 4'hD;
        io_base  = 7'h1C;
        io_wr(10'h261, 8'h66);
        io_wr(10'h0E1, 8'hC9);
        sweep_banks(4'hE);
        sweep_banks(4'hD);

        // R1: reset again clears pages and flags
        cur_req = "R1";
        rst_n = 1'b0; step();
        rst_n = 1'b1; step();
        sweep_banks(4'hD);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            miscompares++;
            $display("FAIL watchdog %s: actual hung expected finished", cur_req);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

endmodule